// File: doc/BRIEF.md
# Per-Flow Segment Generation Engine

This block chooses, once per clock, which transmit segment a network flow sends next. It never handles payload. It works only on segment numbers and buffer addresses. Software opens a flow by giving it a buffer base address, a fixed segment size and a total segment count. The engine then emits descriptors on a valid/ready stream. Each descriptor carries the flow id, the segment index and the byte address of that segment, and a downstream DMA stage uses it to fetch the data. Acknowledgements from the receive side retire segments.

Each flow keeps a bitmap of its outstanding segments over a bounded window. A flow is eligible only while it has unsent segments and its window is not full. The eligible flows form the active set, and a round-robin arbiter draws one of them per cycle. After each draw the flow's state advances at once, so the same flow can be drawn again on the next cycle while it remains eligible.

The descriptor stream follows the usual valid/ready rules. A descriptor stays on the outputs, unchanged, until `seg_ready` is sampled high. While the output register is full and not accepted, no new decision is made. Open, close and acknowledgement inputs are single-cycle strobes with no back-pressure, and the engine takes them on every cycle they are presented.

Top module: `sg_seg_engine`

## Requirements
- R1: After reset, `seg_valid` is low and every flow is closed, so no descriptor appears until a flow is opened.
- R2: An open strobe (re)initialises the flow. Base address, segment size and total are latched, the next index and the window base become 0, and the bitmap is cleared. A flow opened with a total of 0 never produces a descriptor.
- R3: Every descriptor's `seg_addr` equals base + index × size, modulo 2^ADDR_W.
- R4: Eligible flows are served round-robin. After a flow is drawn, the search for the next draw starts at the next higher flow id and wraps past the highest id to 0. With `seg_ready` high, one descriptor is issued per cycle.
- R5: A flow's descriptors carry indices 0, 1, 2, … without gaps, and no index at or above the flow's total is ever issued.
- R6: A flow stops being drawn once its next index minus its window base equals WIN_SEGS.
- R7: An acknowledgement of an outstanding segment clears its bitmap bit (bit = index mod WIN_SEGS). The window base then moves past every contiguous cleared segment. A flow unblocked by this is drawn on the following cycle.
- R8: An acknowledgement of a segment above the window base clears its bit but does not move the base, so a flow blocked by its window stays blocked.
- R9: An acknowledgement is ignored when the flow is closed or when the index is not in the range [window base, next index).
- R10: While `seg_valid` is high and `seg_ready` is low, the descriptor fields hold steady and no flow state advances.
- R11: In a cycle with an open or close strobe no flow is drawn. A closed flow issues no further descriptors.
- R12: Reopening a flow discards its earlier progress, and its next descriptor is index 0 at the new base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| open_valid | input | 1 | Open strobe |
| open_flow | input | FLOW_W | Flow to open |
| open_base | input | ADDR_W | Buffer base address of the flow |
| open_seg_bytes | input | SIZE_W | Fixed segment size in bytes |
| open_seg_total | input | IDX_W | Number of segments to send |
| close_valid | input | 1 | Close strobe |
| close_flow | input | FLOW_W | Flow to close |
| ack_valid | input | 1 | Acknowledgement strobe |
| ack_flow | input | FLOW_W | Acknowledged flow |
| ack_seg | input | IDX_W | Acknowledged segment index |
| seg_valid | output | 1 | Descriptor valid |
| seg_ready | input | 1 | Downstream accepts the descriptor |
| seg_flow | output | FLOW_W | Descriptor flow id |
| seg_id | output | IDX_W | Descriptor segment index |
| seg_addr | output | ADDR_W | Descriptor byte address |

## Verification
An open or close strobe takes effect at the edge where it is sampled, and that edge draws no flow. The first descriptor therefore becomes visible one cycle after that edge. An acknowledgement updates the window at its sampling edge, and a flow it unblocks shows its descriptor after the following edge. With ready held high, one new descriptor follows per cycle. The bench drives and samples on the falling edge. Each check sits exactly at the falling edge where the counted registers make the result visible, and the bench also checks that `seg_valid` is still low one edge earlier.

// File: rtl/sg_pkg.sv
package sg_pkg;

  // Kind of control event that owns the flow table in a given cycle.
  typedef enum logic [1:0] {
    CTL_NONE  = 2'd0,
    CTL_OPEN  = 2'd1,
    CTL_CLOSE = 2'd2
  } sg_ctl_e;

  function automatic sg_ctl_e sg_ctl_kind(input logic open_v, input logic close_v);
    if (open_v)       return CTL_OPEN;
    else if (close_v) return CTL_CLOSE;
    else              return CTL_NONE;
  endfunction

endpackage

// File: rtl/sg_rr_arb.sv
module sg_rr_arb #(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          take,
  output logic          any,
  output logic [IW-1:0] idx
);

  logic [IW-1:0] ptr_q;

  // Search starts at ptr_q and wraps past the highest id to 0.
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      automatic int c = int'(ptr_q) + i;
      if (c >= N) c = c - N;
      if (!any && req[c]) begin
        any = 1'b1;
        idx = IW'(c);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= '0;
    end else if (take && any) begin
      if (int'(idx) == N - 1) ptr_q <= '0;
      else                    ptr_q <= idx + IW'(1);
    end
  end

endmodule

// File: rtl/sg_win_slide.sv
module sg_win_slide #(
  parameter int WIN    = 128,
  parameter int POS_W  = $clog2(WIN),
  parameter int CNT_W  = POS_W + 1
) (
  input  logic [WIN-1:0]   map,
  input  logic [POS_W-1:0] start,
  input  logic [CNT_W-1:0] span,
  output logic [CNT_W-1:0] adv
);

  logic [2*WIN-1:0] twice;
  logic [WIN-1:0]   rot;
  logic [CNT_W-1:0] first_set;

  // Rotate so that the window base sits at bit 0.
  assign twice = {map, map} >> start;
  assign rot   = twice[WIN-1:0];

  // Distance to the first still-outstanding segment.
  always_comb begin
    first_set = span;
    for (int i = WIN - 1; i >= 0; i--) begin
      if (rot[i]) first_set = CNT_W'(i);
    end
  end

  assign adv = (first_set < span) ? first_set : span;

endmodule

// File: rtl/sg_addr_gen.sv
module sg_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 16,
  parameter int SIZE_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  idx,
  input  logic [SIZE_W-1:0] size,
  output logic [ADDR_W-1:0] addr
);

  logic [IDX_W+SIZE_W-1:0] offset;

  assign offset = (IDX_W+SIZE_W)'(idx) * (IDX_W+SIZE_W)'(size);
  assign addr   = base + ADDR_W'(offset);

endmodule

// File: rtl/sg_seg_engine.sv
module sg_seg_engine
  import sg_pkg::*;
#(
  parameter int NUM_FLOWS = 16,
  parameter int WIN_SEGS  = 128,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 16,
  parameter int SIZE_W    = 16,
  parameter int FLOW_W    = $clog2(NUM_FLOWS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_valid,
  input  logic [FLOW_W-1:0] open_flow,
  input  logic [ADDR_W-1:0] open_base,
  input  logic [SIZE_W-1:0] open_seg_bytes,
  input  logic [IDX_W-1:0]  open_seg_total,
  input  logic              close_valid,
  input  logic [FLOW_W-1:0] close_flow,
  input  logic              ack_valid,
  input  logic [FLOW_W-1:0] ack_flow,
  input  logic [IDX_W-1:0]  ack_seg,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [FLOW_W-1:0] seg_flow,
  output logic [IDX_W-1:0]  seg_id,
  output logic [ADDR_W-1:0] seg_addr
);

  localparam int POS_W = $clog2(WIN_SEGS);
  localparam int CNT_W = POS_W + 1;

  // Per-flow state
  logic                fl_open  [NUM_FLOWS];
  logic [ADDR_W-1:0]   fl_base  [NUM_FLOWS];
  logic [SIZE_W-1:0]   fl_size  [NUM_FLOWS];
  logic [IDX_W-1:0]    fl_total [NUM_FLOWS];
  logic [IDX_W-1:0]    fl_next  [NUM_FLOWS];
  logic [IDX_W-1:0]    fl_wbase [NUM_FLOWS];
  logic [WIN_SEGS-1:0] fl_map   [NUM_FLOWS];

  logic [NUM_FLOWS-1:0] elig;

  // Eligibility: open, segments left, window not full
  for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_elig
    logic [IDX_W-1:0] inflight;
    assign inflight = fl_next[g] - fl_wbase[g];
    assign elig[g]  = fl_open[g] && (fl_next[g] < fl_total[g]) &&
                      (inflight < IDX_W'(WIN_SEGS));
  end

  sg_ctl_e ctl_kind;
  logic    load_en;
  logic    gen_fire;
  logic    arb_any;
  logic [FLOW_W-1:0] gen_flow;
  logic [ADDR_W-1:0] gen_addr;

  assign ctl_kind = sg_ctl_kind(open_valid, close_valid);
  assign load_en  = !seg_valid || seg_ready;
  assign gen_fire = load_en && (ctl_kind == CTL_NONE) && arb_any;

  sg_rr_arb #(.N(NUM_FLOWS), .IW(FLOW_W)) u_arb (
    .clk   (clk),
    .rst_n (rst_n),
    .req   (elig),
    .take  (gen_fire),
    .any   (arb_any),
    .idx   (gen_flow)
  );

  sg_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .SIZE_W(SIZE_W)) u_addr (
    .base (fl_base[gen_flow]),
    .idx  (fl_next[gen_flow]),
    .size (fl_size[gen_flow]),
    .addr (gen_addr)
  );

  // Acknowledgement path
  logic [IDX_W-1:0]    ack_rel;
  logic [IDX_W-1:0]    ack_out;
  logic                ack_ctl_clash;
  logic                ack_ok;
  logic [WIN_SEGS-1:0] clr_vec;
  logic [WIN_SEGS-1:0] ack_map;
  logic [CNT_W-1:0]    ack_adv;
  logic [WIN_SEGS-1:0] set_vec;

  assign ack_rel       = ack_seg - fl_wbase[ack_flow];
  assign ack_out       = fl_next[ack_flow] - fl_wbase[ack_flow];
  assign ack_ctl_clash = (open_valid && open_flow == ack_flow) ||
                         (close_valid && close_flow == ack_flow);
  assign ack_ok        = ack_valid && fl_open[ack_flow] && !ack_ctl_clash &&
                         (ack_rel < ack_out);
  assign clr_vec       = ack_ok ? (WIN_SEGS'(1) << ack_seg[POS_W-1:0]) : '0;
  assign ack_map       = fl_map[ack_flow] & ~clr_vec;
  assign set_vec       = gen_fire ? (WIN_SEGS'(1) << fl_next[gen_flow][POS_W-1:0]) : '0;

  sg_win_slide #(.WIN(WIN_SEGS), .POS_W(POS_W), .CNT_W(CNT_W)) u_slide (
    .map   (ack_map),
    .start (fl_wbase[ack_flow][POS_W-1:0]),
    .span  (CNT_W'(ack_out)),
    .adv   (ack_adv)
  );

  // Flow table update
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int f = 0; f < NUM_FLOWS; f++) begin
        fl_open[f]  <= 1'b0;
        fl_base[f]  <= '0;
        fl_size[f]  <= '0;
        fl_total[f] <= '0;
        fl_next[f]  <= '0;
        fl_wbase[f] <= '0;
        fl_map[f]   <= '0;
      end
    end else begin
      for (int f = 0; f < NUM_FLOWS; f++) begin
        if (ctl_kind == CTL_OPEN && open_flow == FLOW_W'(f)) begin
          fl_open[f]  <= 1'b1;
          fl_base[f]  <= open_base;
          fl_size[f]  <= open_seg_bytes;
          fl_total[f] <= open_seg_total;
          fl_next[f]  <= '0;
          fl_wbase[f] <= '0;
          fl_map[f]   <= '0;
        end else if (close_valid && close_flow == FLOW_W'(f)) begin
          fl_open[f] <= 1'b0;
        end else begin
          if (gen_fire && gen_flow == FLOW_W'(f))
            fl_next[f] <= fl_next[f] + IDX_W'(1);
          if (ack_ok && ack_flow == FLOW_W'(f))
            fl_wbase[f] <= fl_wbase[f] + IDX_W'(ack_adv);
          fl_map[f] <= (fl_map[f] & ~((ack_ok && ack_flow == FLOW_W'(f)) ? clr_vec : '0)) |
                       ((gen_fire && gen_flow == FLOW_W'(f)) ? set_vec : '0);
        end
      end
    end
  end

  // Descriptor output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg_valid <= 1'b0;
      seg_flow  <= '0;
      seg_id    <= '0;
      seg_addr  <= '0;
    end else if (load_en) begin
      seg_valid <= gen_fire;
      if (gen_fire) begin
        seg_flow <= gen_flow;
        seg_id   <= fl_next[gen_flow];
        seg_addr <= gen_addr;
      end
    end
  end

endmodule

// File: rtl/sg_seg_engine_chk.sv
module sg_seg_engine_chk #(
  parameter int NUM_FLOWS = 16,
  parameter int ADDR_W    = 32,
  parameter int IDX_W     = 16,
  parameter int FLOW_W    = $clog2(NUM_FLOWS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              open_valid,
  input logic [FLOW_W-1:0] open_flow,
  input logic [IDX_W-1:0]  open_seg_total,
  input logic              close_valid,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [FLOW_W-1:0] seg_flow,
  input logic [IDX_W-1:0]  seg_id,
  input logic [ADDR_W-1:0] seg_addr
);

  // Totals seen at open, and whether an open arrived since the last handshake
  logic [IDX_W-1:0] tot_q [NUM_FLOWS];
  logic             open_seen;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      open_seen <= 1'b0;
      for (int f = 0; f < NUM_FLOWS; f++) tot_q[f] <= '0;
    end else begin
      if (open_valid) begin
        tot_q[open_flow] <= open_seg_total;
        open_seen        <= 1'b1;
      end else if (seg_valid && seg_ready) begin
        open_seen <= 1'b0;
      end
    end
  end

  // R10: stalled descriptor holds steady
  a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !seg_ready |=> seg_valid && $stable(seg_flow) &&
                                $stable(seg_id) && $stable(seg_addr));

  // R11: control strobe cycles load no new descriptor
  a_r11_ctl_no_load: assert property (@(posedge clk) disable iff (!rst_n)
    (open_valid || close_valid) && (!seg_valid || seg_ready) |=> !seg_valid);

  // R5: back-to-back descriptors of one flow are consecutive
  a_r5_consecutive_ids: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && seg_ready && !open_seen && !open_valid |=>
      (!seg_valid || seg_flow != $past(seg_flow) || seg_id == $past(seg_id) + IDX_W'(1)));

  // R5: no index at or beyond the flow total
  a_r5_below_total: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid && !open_seen |-> seg_id < tot_q[seg_flow]);

endmodule

bind sg_seg_engine sg_seg_engine_chk #(
  .NUM_FLOWS (NUM_FLOWS),
  .ADDR_W    (ADDR_W),
  .IDX_W     (IDX_W),
  .FLOW_W    (FLOW_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .open_valid     (open_valid),
  .open_flow      (open_flow),
  .open_seg_total (open_seg_total),
  .close_valid    (close_valid),
  .seg_valid      (seg_valid),
  .seg_ready      (seg_ready),
  .seg_flow       (seg_flow),
  .seg_id         (seg_id),
  .seg_addr       (seg_addr)
);

// File: tb/sg_seg_engine_bench.sv
module sg_seg_engine_bench;

  localparam int NF  = 4;
  localparam int WIN = 8;
  localparam int AW  = 32;
  localparam int IW  = 16;
  localparam int SW  = 16;
  localparam int FW  = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          open_valid = 1'b0;
  logic [FW-1:0] open_flow = '0;
  logic [AW-1:0] open_base = '0;
  logic [SW-1:0] open_seg_bytes = '0;
  logic [IW-1:0] open_seg_total = '0;
  logic          close_valid = 1'b0;
  logic [FW-1:0] close_flow = '0;
  logic          ack_valid = 1'b0;
  logic [FW-1:0] ack_flow = '0;
  logic [IW-1:0] ack_seg = '0;
  logic          seg_valid;
  logic          seg_ready = 1'b1;
  logic [FW-1:0] seg_flow;
  logic [IW-1:0] seg_id;
  logic [AW-1:0] seg_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sg_seg_engine #(
    .NUM_FLOWS(NF), .WIN_SEGS(WIN), .ADDR_W(AW), .IDX_W(IW), .SIZE_W(SW), .FLOW_W(FW)
  ) u_sg_seg_engine (
    .clk(clk), .rst_n(rst_n),
    .open_valid(open_valid), .open_flow(open_flow), .open_base(open_base),
    .open_seg_bytes(open_seg_bytes), .open_seg_total(open_seg_total),
    .close_valid(close_valid), .close_flow(close_flow),
    .ack_valid(ack_valid), .ack_flow(ack_flow), .ack_seg(ack_seg),
    .seg_valid(seg_valid), .seg_ready(seg_ready),
    .seg_flow(seg_flow), .seg_id(seg_id), .seg_addr(seg_addr)
  );

  // Stimulus table: flow, base, size, total
  localparam int NV = 6;
  localparam logic [FW-1:0] TV_FLOW [NV] = '{2'd0, 2'd1, 2'd2, 2'd3, 2'd1, 2'd2};
  localparam logic [AW-1:0] TV_BASE [NV] = '{32'h0000_1000, 32'h2000_0000, 32'h0001_0000,
                                             32'hFFFF_FF00, 32'h0000_0010, 32'h0000_0500};
  localparam logic [SW-1:0] TV_SIZE [NV] = '{16'd64, 16'd128, 16'd1500, 16'h0040, 16'd1, 16'd8};
  localparam logic [IW-1:0] TV_TOT  [NV] = '{16'd3, 16'd8, 16'd5, 16'd6, 16'd1, 16'd0};

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(seg_valid == 1'b0, req, "seg_valid", longint'(seg_valid), 0);
  endtask

  task automatic chk_desc(input string req, input int fl, input int id, input logic [AW-1:0] ad);
    chk(seg_valid == 1'b1, req, "seg_valid", longint'(seg_valid), 1);
    chk(int'(seg_flow) == fl, req, "seg_flow", longint'(seg_flow), longint'(fl));
    chk(int'(seg_id) == id, req, "seg_id", longint'(seg_id), longint'(id));
    chk(seg_addr == ad, req, "seg_addr", longint'(seg_addr), longint'(ad));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Drive an open at the current negedge; returns at the next negedge with strobe cleared
  task automatic open_flow_now(input int fl, input logic [AW-1:0] b,
                               input logic [SW-1:0] sz, input logic [IW-1:0] tot);
    open_valid = 1'b1; open_flow = FW'(fl); open_base = b;
    open_seg_bytes = sz; open_seg_total = tot;
    @(negedge clk);
    open_valid = 1'b0;
  endtask

  task automatic ack_now(input int fl, input int s);
    ack_valid = 1'b1; ack_flow = FW'(fl); ack_seg = IW'(s);
    @(negedge clk);
    ack_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk_idle("R1");

    // Table walk: one flow at a time, drained with ready high
    for (int v = 0; v < NV; v++) begin
      open_flow_now(int'(TV_FLOW[v]), TV_BASE[v], TV_SIZE[v], TV_TOT[v]);
      chk_idle("R11");
      for (int i = 0; i < int'(TV_TOT[v]); i++) begin
        @(negedge clk);
        chk_desc("R3", int'(TV_FLOW[v]), i,
                 TV_BASE[v] + AW'(i) * AW'(TV_SIZE[v]));
      end
      @(negedge clk);
      chk_idle(TV_TOT[v] == 0 ? "R2" : "R5");
      close_valid = 1'b1; close_flow = TV_FLOW[v];
      @(negedge clk);
      close_valid = 1'b0;
    end

    // Round-robin and back-pressure
    do_reset();
    seg_ready = 1'b0;
    open_flow_now(0, 32'h100, 16'd16, 16'd3);
    open_flow_now(1, 32'h200, 16'd32, 16'd3);
    open_flow_now(2, 32'h300, 16'd48, 16'd3);
    @(negedge clk);
    chk_desc("R4", 0, 0, 32'h100);
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk_desc("R10", 0, 0, 32'h100);
    end
    seg_ready = 1'b1;
    for (int k = 0; k < 9; k++) begin
      if (k > 0) @(negedge clk);
      chk_desc("R4", k % 3, k / 3, AW'(32'h100 * (k % 3 + 1)) + AW'((k / 3) * 16 * (k % 3 + 1)));
    end
    @(negedge clk);
    chk_idle("R5");

    // Window limit and acknowledgements on flow 3
    open_flow_now(3, 32'h1000, 16'd64, 16'd20);
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      chk_desc("R6", 3, i, 32'h1000 + AW'(i * 64));
    end
    @(negedge clk);
    chk_idle("R6");
    ack_now(3, 2);
    chk_idle("R8");
    @(negedge clk);
    chk_idle("R8");
    ack_now(3, 0);
    chk_idle("R7");
    @(negedge clk);
    chk_desc("R7", 3, 8, 32'h1000 + 32'd512);
    @(negedge clk);
    chk_idle("R6");
    ack_now(3, 1);
    chk_idle("R7");
    @(negedge clk);
    chk_desc("R7", 3, 9, 32'h1000 + 32'd576);
    @(negedge clk);
    chk_desc("R7", 3, 10, 32'h1000 + 32'd640);
    @(negedge clk);
    chk_idle("R7");

    // Out-of-range acks: beyond next index, and beyond flow 0's outstanding span
    ack_now(3, 15);
    chk_idle("R9");
    ack_now(0, 5);
    chk_idle("R9");

    // Acks 3..6 must free exactly four more segments (11..14)
    begin
      int got = 0;
      int exp_id = 11;
      for (int k = 0; k < 12; k++) begin
        @(negedge clk);
        if (seg_valid) begin
          chk_desc("R9", 3, exp_id, 32'h1000 + AW'(exp_id * 64));
          exp_id++;
          got++;
        end
        if (k < 4) begin
          ack_valid = 1'b1; ack_flow = 2'd3; ack_seg = IW'(3 + k);
        end else begin
          ack_valid = 1'b0;
        end
      end
      chk(got == 4, "R9", "descriptors after acks", longint'(got), 4);
    end

    // Reopen discards progress
    @(negedge clk);
    open_flow_now(3, 32'h8000, 16'd100, 16'd2);
    @(negedge clk);
    chk_desc("R12", 3, 0, 32'h8000);
    @(negedge clk);
    chk_desc("R12", 3, 1, 32'h8064);
    @(negedge clk);
    chk_idle("R12");

    // Close mid-stream
    open_flow_now(2, 32'h4000, 16'd8, 16'd6);
    @(negedge clk);
    chk_desc("R11", 2, 0, 32'h4000);
    close_valid = 1'b1; close_flow = 2'd2;
    @(negedge clk);
    close_valid = 1'b0;
    chk_idle("R11");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk_idle("R11");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule